// File: doc/BRIEF.md
# Strided Masked Gather Load Engine

This engine fills a destination vector of `LANES` elements by reading separate memory locations one lane at a time. A start pulse captures a scalar base address, a signed scalar stride, a per-lane enable mask, an active length and a bias flag. Lane `i` reads from `base + i*stride`, wrapping modulo the address width. A lane is read only when its mask bit is set and its index lies below the effective limit, which is the length minus one when the bias flag is set and the length otherwise. Every other lane is written with zero and makes no memory access.

The engine walks the lanes in ascending order and keeps at most one read outstanding on a simple request/response port. A suppressed lane takes one cycle. A read lane takes one cycle for the request plus the wait for its response. When the last lane has been handled, the engine raises `done` for a single cycle, and the assembled vector is then available on `vec_out`.

Top module: `strided_gather_engine`

## Requirements
- R1: The read request for lane i carries address `base + i*stride` modulo 2^ADDR_W, where the stride is taken as a two's-complement signed value, so a negative stride walks downward in memory.
- R2: The effective limit is `len` when `bias_neg` is 0 and `len - 1` when `bias_neg` is 1, with `len = 0` and `bias_neg = 1` giving a limit of zero. A lane whose index is at or above the limit issues no request and is written as zero.
- R3: A lane whose mask bit is 0 issues no request and is written as zero.
- R4: Mask bits of lanes at or above the effective limit have no effect: such lanes are zeroed and unread even when their mask bit is 1.
- R5: Lanes are handled in ascending index order. After a request, `mem_req` stays low until that request's response has been accepted.
- R6: `start` is accepted only while the engine is idle. It latches base, stride, mask, length and bias. Changes to those inputs after that, including another `start` pulse while busy, do not alter the run.
- R7: `done` is high for exactly one cycle, in the cycle after the last lane completes. `busy` is high from the cycle after `start` through the `done` cycle.
- R8: After reset, `done`, `busy` and `mem_req` are low and `vec_out` is all zero.
- R9: A lane that is read holds exactly the `mem_rsp_data` returned for its request. Lane i occupies bits `[i*DATA_W +: DATA_W]` of `vec_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a gather when idle |
| base_addr | input | ADDR_W | Address of lane 0 |
| stride | input | ADDR_W | Signed distance between consecutive lanes |
| lane_mask | input | LANES | Per-lane read enable, bit i for lane i |
| active_len | input | LEN_W | Number of lanes before bias |
| bias_neg | input | 1 | 1 selects a bias of -1, 0 a bias of 0 |
| mem_req | output | 1 | Read request strobe, one cycle |
| mem_addr | output | ADDR_W | Read address |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | DATA_W | Read data |
| busy | output | 1 | A gather is in progress |
| done | output | 1 | One-cycle completion pulse |
| vec_out | output | LANES*DATA_W | Assembled destination vector |

## Verification
The bench uses the default build: 8 lanes of 32-bit data and 16-bit addresses. With 8 lanes, a single run can include a read lane, a masked lane and a lane beyond the limit together. With 16-bit addresses, a negative stride wraps below zero within a few lanes. The memory model answers one cycle after each request. The reference model therefore predicts the cycle of every request and of `done` exactly, and compares `mem_req`, `mem_addr`, `busy` and `done` against that prediction on every clock. The limit corner cases are covered: a zero length with a negative bias, and a full length with a negative bias that drops the last lane even though its mask bit is set.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_LANE = 2'd1,
    GS_WAIT = 2'd2,
    GS_FIN  = 2'd3
  } gstate_t;
endpackage

// File: rtl/lane_gate.sv
// Decides whether the current lane is fetched from memory.
module lane_gate #(
  parameter int LANES = 8,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] mask,
  input  logic [LEN_W-1:0] len,
  input  logic             bias_neg,
  output logic             fetch
);
  logic [LEN_W:0] idx_plus_bias;
  logic           in_range;

  // idx < len - bias  <=>  idx + bias < len, so no negative value is formed.
  always_comb begin
    idx_plus_bias = (LEN_W+1)'(idx) + (LEN_W+1)'(bias_neg);
    in_range      = idx_plus_bias < (LEN_W+1)'(len);
    fetch         = in_range && mask[idx];
  end
endmodule

// File: rtl/addr_stepper.sv
// Running lane address: loaded with the base, advanced by the stride.
module addr_stepper #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_d, addr_q;

  always_comb begin
    addr_d = addr_q;
    if (load)      addr_d = base;
    else if (step) addr_d = addr_q + stride;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addr_q <= '0;
    else if (load || step) addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/result_bank.sv
// Destination vector, one register per lane.
module result_bank #(
  parameter int LANES  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_zero,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [LANES*DATA_W-1:0] vec
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              sel;
    logic [DATA_W-1:0] lane_d, lane_q;

    always_comb begin
      sel    = wr_en && (wr_idx == IDX_W'(g));
      lane_d = wr_zero ? '0 : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lane_q <= '0;
      else if (sel) lane_q <= lane_d;
    end

    assign vec[g*DATA_W +: DATA_W] = lane_q;

    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_zero && wr_idx == IDX_W'(g)) |=> (lane_q == '0));
  end
endmodule

// File: rtl/strided_gather_engine.sv
module strided_gather_engine #(
  parameter int LANES  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       base_addr,
  input  logic [ADDR_W-1:0]       stride,
  input  logic [LANES-1:0]        lane_mask,
  input  logic [LEN_W-1:0]        active_len,
  input  logic                    bias_neg,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_rsp_valid,
  input  logic [DATA_W-1:0]       mem_rsp_data,
  output logic                    busy,
  output logic                    done,
  output logic [LANES*DATA_W-1:0] vec_out
);
  import gather_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  gstate_t           state_d, state_q;
  logic [IDX_W-1:0]  idx_d, idx_q;
  logic [ADDR_W-1:0] stride_q;
  logic [LANES-1:0]  mask_q;
  logic [LEN_W-1:0]  len_q;
  logic              bias_q;
  logic              load, step, wr_en, wr_zero, req, fetch, last;

  lane_gate #(.LANES(LANES)) u_gate (
    .idx(idx_q), .mask(mask_q), .len(len_q), .bias_neg(bias_q), .fetch(fetch)
  );

  addr_stepper #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_ns), .load(load), .step(step),
    .base(base_addr), .stride(stride_q), .addr(mem_addr)
  );

  result_bank #(.LANES(LANES), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .wr_zero(wr_zero),
    .wr_idx(idx_q), .wr_data(mem_rsp_data), .vec(vec_out)
  );

  assign last = (idx_q == IDX_W'(LANES - 1));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    load    = 1'b0;
    step    = 1'b0;
    wr_en   = 1'b0;
    wr_zero = 1'b0;
    req     = 1'b0;
    case (state_q)
      GS_IDLE: if (start) begin
        load    = 1'b1;
        idx_d   = '0;
        state_d = GS_LANE;
      end
      GS_LANE: if (fetch) begin
        req     = 1'b1;
        state_d = GS_WAIT;
      end else begin
        wr_en   = 1'b1;
        wr_zero = 1'b1;
        step    = 1'b1;
        if (last) state_d = GS_FIN;
        else      idx_d   = idx_q + 1'b1;
      end
      GS_WAIT: if (mem_rsp_valid) begin
        wr_en   = 1'b1;
        step    = 1'b1;
        if (last) state_d = GS_FIN;
        else begin
          idx_d   = idx_q + 1'b1;
          state_d = GS_LANE;
        end
      end
      default: state_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= GS_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      stride_q <= '0;
      mask_q   <= '0;
      len_q    <= '0;
      bias_q   <= 1'b0;
    end else if (load) begin
      stride_q <= stride;
      mask_q   <= lane_mask;
      len_q    <= active_len;
      bias_q   <= bias_neg;
    end
  end

  assign mem_req = req;
  assign busy    = (state_q != GS_IDLE);
  assign done    = (state_q == GS_FIN);

  assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req |=> !mem_req);
  assert_ascending_lanes_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && $past(busy) && idx_q != $past(idx_q)) |-> (idx_q == $past(idx_q) + 1'b1));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    !busy |-> (!mem_req && !done));
endmodule

// File: tb/strided_gather_engine_test.sv
`timescale 1ns/1ps
module strided_gather_engine_test;
  localparam int LANES = 8, DW = 32, AW = 16, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bias_neg = 1'b0;
  logic [AW-1:0] base_addr = '0, stride = '0, mem_addr;
  logic [LANES-1:0] lane_mask = '0;
  logic [LW-1:0] active_len = '0;
  logic mem_req, mem_rsp_valid = 1'b0, busy, done;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [LANES*DW-1:0] vec_out;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  strided_gather_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .stride(stride), .lane_mask(lane_mask), .active_len(active_len),
    .bias_neg(bias_neg), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .busy(busy), .done(done), .vec_out(vec_out)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  // Memory: answers each request one cycle later.
  always @(posedge clk) begin
    mem_rsp_valid <= mem_req;
    mem_rsp_data  <= mem_word(mem_addr);
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [LANES*DW-1:0] act, input logic [LANES*DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [AW-1:0] b, input logic [AW-1:0] s,
                          input logic [LANES-1:0] m, input logic [LW-1:0] l,
                          input logic bn, input bit inj);
    int lim;
    logic [LANES*DW-1:0] exp_vec;
    logic [AW-1:0] a;
    lim = int'(l) - int'(bn);
    exp_vec = '0;
    @(negedge clk);
    base_addr = b; stride = s; lane_mask = m; active_len = l; bias_neg = bn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base_addr = ~b; stride = s + 16'd7; lane_mask = ~m; active_len = 4'd8; bias_neg = ~bn;
    for (int i = 0; i < LANES; i++) begin
      a = b + 16'(i) * s;
      chk(busy === 1'b1 && done === 1'b0, "R7 busy during run", {busy, done}, 2'b10);
      if (inj && i == 1) start = 1'b1;
      if (inj && i == 2) start = 1'b0;
      if (m[i] && i < lim) begin
        exp_vec[i*DW +: DW] = mem_word(a);
        chk(mem_req === 1'b1 && mem_addr === a, "R1 lane request address",
            {mem_req, mem_addr}, {1'b1, a});
        @(negedge clk);
        chk(mem_req === 1'b0, "R5 no request while waiting", mem_req, 1'b0);
      end else begin
        chk(mem_req === 1'b0, (i >= lim) ? (m[i] ? "R4 mask beyond limit" : "R2 lane beyond limit")
                                         : "R3 masked lane", mem_req, 1'b0);
      end
      @(negedge clk);
    end
    chk(done === 1'b1 && busy === 1'b1, "R7 done pulse", {done, busy}, 2'b11);
    chk(vec_out === exp_vec, inj ? "R6 start ignored while busy" : "R9 vector contents",
        vec_out, exp_vec);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && mem_req === 1'b0, "R7 done single cycle",
        {done, busy, mem_req}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && mem_req === 1'b0, "R8 reset outputs",
        {done, busy, mem_req}, 3'b000);
    chk(vec_out === '0, "R8 reset vector", vec_out, '0);
    run_case(16'h0100, 16'd4,      8'hFF,        4'd8, 1'b0, 1'b0);
    run_case(16'h0010, 16'hFFFD,   8'hFF,        4'd8, 1'b1, 1'b0);
    run_case(16'h2000, 16'd12,     8'b1010_0101, 4'd5, 1'b0, 1'b0);
    run_case(16'h3000, 16'd1,      8'hFF,        4'd0, 1'b1, 1'b0);
    run_case(16'h4000, 16'd8,      8'h80,        4'd8, 1'b1, 1'b0);
    run_case(16'h5000, 16'd32,     8'h3C,        4'd6, 1'b0, 1'b1);
    run_case(16'hFFF0, 16'd0,      8'h5B,        4'd7, 1'b0, 1'b0);
    run_case(16'hFFF8, 16'd5,      8'hE7,        4'd8, 1'b0, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule